// File: doc/BRIEF.md
# Rectangle Copy Engine for Pixel Memory

This block moves a rectangle of 16-bit pixels from one place to another inside a 1024-column by 512-row pixel memory. A controller presents three 32-bit parameter words (where to read from, where to write to, and the rectangle's extent) together with a one-cycle start strobe and a mask-force flag. The engine then walks the rectangle row by row through a single-port memory interface, with busy raised for the whole transfer and a done pulse at the end.

Each row is cut into pieces of at most 128 pixels. For every piece, all pixels are first read into an internal buffer, one idle cycle lets the last read return, and then the buffered pixels are written to the destination. Both corners wrap on each axis, so a rectangle may run off the right or bottom edge and continue on the left or top edge. When the mask-force flag is set, every written pixel has its top bit set. A copy onto itself with mask forcing off does no memory traffic at all.

State machine: `ST_IDLE` waits for start; *accept* goes to `ST_READ`, or *skip* goes straight to `ST_DONE`. `ST_READ` issues one read per cycle, and *piece read* moves to `ST_DRAIN`. `ST_DRAIN` always moves on to `ST_WRITE`. `ST_WRITE` writes one pixel per cycle. From there, *next piece* or *next row* returns to `ST_READ`, and *last write* goes to `ST_DONE`. `ST_DONE` always returns to `ST_IDLE`.

Top module: `rect_copy_engine`

## Requirements
- R1: Corner words carry the column in bits 9:0 and the row in bits 24:16; all other bits are ignored. In the extent word, bits 9:0 give the width and bits 24:16 give the height. A field value of 0 means 1024 columns or 512 rows.
- R2: The pixel address is row*1024 + column. Source and destination columns wrap modulo 1024, and rows wrap modulo 512.
- R3: A row is handled in pieces of at most 128 pixels, from left to right. Each piece is all of its reads (one per cycle), then exactly one cycle with neither read nor write, then all of its writes (one per cycle) in the same pixel order. Read and write are never active in the same cycle.
- R4: A piece's reads see every write of earlier pieces. For overlapping rectangles, the result is the one produced by that piece-wise order.
- R5: When the mask-force flag is high with start, every written pixel equals the read pixel with bit 15 set. Otherwise the pixel is written unchanged.
- R6: When both corners are equal and mask-force is low, done pulses in the cycle after start, with no read, no write and busy low.
- R7: Rows are processed in increasing order of offset from the top of the rectangle.
- R8: Busy is high from the cycle after start through the cycle of the final write. Done is high for exactly the next cycle, with busy low, and the engine is idle after that.
- R9: Read data is taken one cycle after the read request.
- R10: After reset, busy, done, read request and write request are all low.
- R11: A start strobe while busy is ignored. The transfer in flight continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a copy |
| pos_src | input | 32 | Source corner word |
| pos_dst | input | 32 | Destination corner word |
| ext_size | input | 32 | Extent word |
| set_mask | input | 1 | Force bit 15 on written pixels |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 19 | Pixel address, row*1024 + column |
| mem_re | output | 1 | Read request |
| mem_we | output | 1 | Write request |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid one cycle after the request |

## Verification
The embedded assertions check the following on every cycle:
- Read and write never coincide.
- The idle gap always falls between a piece's reads and its writes.
- Done lasts one cycle and never overlaps busy or memory traffic.
- Forced writes carry bit 15.
- The row offset only ever steps up by one.
- An accepted start always leads to busy or done.

Only the bench's reference model can show that the addresses and pixel values are right in every cycle. That covers wrap on both axes, the zero-means-maximum extents, the piece boundaries at 128 and 129 pixels, and the results of overlapping copies. The model also shows that a copy onto itself is skipped and that a second start during a transfer changes nothing.

// File: rtl/rcopy_pkg.sv
package rcopy_pkg;
    localparam int RC_COL_W = 10;
    localparam int RC_ROW_W = 9;
    localparam int RC_PIX_W = 16;
    localparam int RC_CHUNK = 128;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_DRAIN,
        ST_WRITE,
        ST_DONE
    } rc_state_e;
endpackage

// File: rtl/rcopy_decode.sv
// Splits the three parameter words into corners and extent.
module rcopy_decode #(
    parameter int COL_W = 10,
    parameter int ROW_W = 9
) (
    input  logic [31:0]      pos_src,
    input  logic [31:0]      pos_dst,
    input  logic [31:0]      ext_size,
    output logic [COL_W-1:0] src_x,
    output logic [ROW_W-1:0] src_y,
    output logic [COL_W-1:0] dst_x,
    output logic [ROW_W-1:0] dst_y,
    output logic [COL_W:0]   width,
    output logic [ROW_W:0]   height,
    output logic             same_spot
);
    logic unused_hi;

    assign src_x = pos_src[COL_W-1:0];
    assign src_y = pos_src[16 +: ROW_W];
    assign dst_x = pos_dst[COL_W-1:0];
    assign dst_y = pos_dst[16 +: ROW_W];

    // A zero field selects the full axis length.
    assign width  = (ext_size[COL_W-1:0] == '0) ? {1'b1, {COL_W{1'b0}}}
                                                : {1'b0, ext_size[COL_W-1:0]};
    assign height = (ext_size[16 +: ROW_W] == '0) ? {1'b1, {ROW_W{1'b0}}}
                                                  : {1'b0, ext_size[16 +: ROW_W]};

    assign same_spot = (src_x == dst_x) && (src_y == dst_y);

    assign unused_hi = ^{pos_src[31:16+ROW_W], pos_src[15:COL_W],
                         pos_dst[31:16+ROW_W], pos_dst[15:COL_W],
                         ext_size[31:16+ROW_W], ext_size[15:COL_W]};
endmodule

// File: rtl/rcopy_chunkbuf.sv
// Register bank holding one piece of a row between its reads and writes.
module rcopy_chunkbuf #(
    parameter int DEPTH = 128,
    parameter int PIX_W = 16,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PIX_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [PIX_W-1:0] rd_data
);
    logic [PIX_W-1:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                cells[g] <= wr_data;
            end
        end
    end

    assign rd_data = cells[rd_idx];
endmodule

// File: rtl/rect_copy_engine.sv
module rect_copy_engine
    import rcopy_pkg::*;
#(
    parameter int COL_W = RC_COL_W,
    parameter int ROW_W = RC_ROW_W,
    parameter int PIX_W = RC_PIX_W,
    parameter int CHUNK = RC_CHUNK
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [31:0]            pos_src,
    input  logic [31:0]            pos_dst,
    input  logic [31:0]            ext_size,
    input  logic                   set_mask,
    output logic                   busy,
    output logic                   done,
    output logic [COL_W+ROW_W-1:0] mem_addr,
    output logic                   mem_re,
    output logic                   mem_we,
    output logic [PIX_W-1:0]       mem_wdata,
    input  logic [PIX_W-1:0]       mem_rdata
);
    localparam int CIDX_W = $clog2(CHUNK);
    localparam int CLEN_W = CIDX_W + 1;
    localparam int WID_W  = COL_W + 1;
    localparam int HGT_W  = ROW_W + 1;

    rc_state_e state, state_nx;

    // Decoded parameter words
    logic [COL_W-1:0] d_sx, d_dx;
    logic [ROW_W-1:0] d_sy, d_dy;
    logic [WID_W-1:0] d_w;
    logic [HGT_W-1:0] d_h;
    logic             d_same;

    // Latched transfer description
    logic [COL_W-1:0] sx_q, dx_q;
    logic [ROW_W-1:0] sy_q, dy_q;
    logic [WID_W-1:0] w_q;
    logic [HGT_W-1:0] h_q;
    logic             mask_q;

    // Walk position
    logic [HGT_W-1:0]  row_cnt;
    logic [WID_W-1:0]  col0;
    logic [CIDX_W-1:0] idx;
    logic              cap_en;
    logic [CIDX_W-1:0] cap_idx;

    logic [WID_W-1:0]  remaining;
    logic [CLEN_W-1:0] clen;
    logic              piece_end, col_more, row_more;
    logic [ROW_W-1:0]  rd_row, wr_row;
    logic [COL_W-1:0]  rd_col, wr_col;
    logic [PIX_W-1:0]  buf_q;

    rcopy_decode #(.COL_W(COL_W), .ROW_W(ROW_W)) u_decode (
        .pos_src  (pos_src),
        .pos_dst  (pos_dst),
        .ext_size (ext_size),
        .src_x    (d_sx),
        .src_y    (d_sy),
        .dst_x    (d_dx),
        .dst_y    (d_dy),
        .width    (d_w),
        .height   (d_h),
        .same_spot(d_same)
    );

    rcopy_chunkbuf #(.DEPTH(CHUNK), .PIX_W(PIX_W), .IDX_W(CIDX_W)) u_chunkbuf (
        .clk    (clk),
        .wr_en  (cap_en),
        .wr_idx (cap_idx),
        .wr_data(mem_rdata),
        .rd_idx (idx),
        .rd_data(buf_q)
    );

    // Piece length, end of piece, what follows the piece
    assign remaining = w_q - col0;
    assign clen      = (remaining > WID_W'(CHUNK)) ? CLEN_W'(CHUNK) : CLEN_W'(remaining);
    assign piece_end = (idx == CIDX_W'(clen - 1'b1));
    assign col_more  = ((col0 + WID_W'(clen)) < w_q);
    assign row_more  = ((row_cnt + 1'b1) < h_q);

    // Wrapped coordinates: truncation to the axis width gives the wrap
    assign rd_row = sy_q + ROW_W'(row_cnt);
    assign wr_row = dy_q + ROW_W'(row_cnt);
    assign rd_col = sx_q + COL_W'(col0) + COL_W'(idx);
    assign wr_col = dx_q + COL_W'(col0) + COL_W'(idx);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nx = (d_same && !set_mask) ? ST_DONE : ST_READ;
                end
            end
            ST_READ: begin
                if (piece_end) begin
                    state_nx = ST_DRAIN;
                end
            end
            ST_DRAIN: state_nx = ST_WRITE;
            ST_WRITE: begin
                if (piece_end) begin
                    state_nx = (col_more || row_more) ? ST_READ : ST_DONE;
                end
            end
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy      = (state == ST_READ) || (state == ST_DRAIN) || (state == ST_WRITE);
        done      = (state == ST_DONE);
        mem_re    = (state == ST_READ);
        mem_we    = (state == ST_WRITE);
        mem_addr  = (state == ST_WRITE) ? {wr_row, wr_col} : {rd_row, rd_col};
        mem_wdata = buf_q | {mask_q, {(PIX_W-1){1'b0}}};
    end

    // Walk counters and latched description
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sx_q    <= '0;
            sy_q    <= '0;
            dx_q    <= '0;
            dy_q    <= '0;
            w_q     <= '0;
            h_q     <= '0;
            mask_q  <= 1'b0;
            row_cnt <= '0;
            col0    <= '0;
            idx     <= '0;
            cap_en  <= 1'b0;
            cap_idx <= '0;
        end else begin
            cap_en  <= (state == ST_READ);
            cap_idx <= idx;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        sx_q    <= d_sx;
                        sy_q    <= d_sy;
                        dx_q    <= d_dx;
                        dy_q    <= d_dy;
                        w_q     <= d_w;
                        h_q     <= d_h;
                        mask_q  <= set_mask;
                        row_cnt <= '0;
                        col0    <= '0;
                        idx     <= '0;
                    end
                end
                ST_READ: begin
                    idx <= piece_end ? '0 : idx + 1'b1;
                end
                ST_WRITE: begin
                    if (piece_end) begin
                        idx <= '0;
                        if (col_more) begin
                            col0 <= col0 + WID_W'(clen);
                        end else begin
                            col0    <= '0;
                            row_cnt <= row_cnt + 1'b1;
                        end
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Checks next to the logic they guard
    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we)); // R3

    AST_GAP_BEFORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> !$past(mem_re)); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !mem_re && !mem_we)); // R8

    AST_ACCEPT_ACTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (busy || done)); // R8

    AST_MASK_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mask_q) |-> mem_wdata[PIX_W-1]); // R5

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (row_cnt != $past(row_cnt)))
            |-> (row_cnt == $past(row_cnt) + 1'b1)); // R7

    AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && d_same && !set_mask) |=> (done && !mem_re && !mem_we)); // R6
endmodule

// File: tb/rect_copy_engine_bench.sv
module rect_copy_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] pos_src = '0;
    logic [31:0] pos_dst = '0;
    logic [31:0] ext_size = '0;
    logic        set_mask = 1'b0;
    logic        busy, done, mem_re, mem_we;
    logic [18:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;

    int n_cmp = 0;
    int n_bad = 0;

    logic [15:0] dmem [int];
    logic [15:0] rmem [int];
    int q_kind[$];
    int q_addr[$];
    int q_data[$];

    always #4 clk = ~clk; // 125 MHz

    rect_copy_engine u_rect_copy_engine (
        .clk(clk), .rst_n(rst_n), .start(start),
        .pos_src(pos_src), .pos_dst(pos_dst), .ext_size(ext_size),
        .set_mask(set_mask), .busy(busy), .done(done),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [15:0] init_pix(int a);
        return 16'((a * 37 + 11) & 32'h7fff);
    endfunction

    function automatic logic [15:0] dget(int a);
        if (dmem.exists(a)) return dmem[a];
        return init_pix(a);
    endfunction

    function automatic logic [15:0] rget(int a);
        if (rmem.exists(a)) return rmem[a];
        return init_pix(a);
    endfunction

    // Pixel memory with one-cycle read latency (R9)
    always @(posedge clk) begin
        if (mem_we) dmem[int'(mem_addr)] = mem_wdata;
        if (mem_re) mem_rdata <= dget(int'(mem_addr));
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
        $finish;
    end

    // kinds: 0 gap, 1 read, 2 write, 3 done, 4 idle
    task automatic cmp(string tag, int kind, int addr, int data);
        logic ok;
        logic e_re, e_we, e_busy, e_done;
        e_re   = (kind == 1);
        e_we   = (kind == 2);
        e_busy = (kind <= 2);
        e_done = (kind == 3);
        ok = (mem_re == e_re) && (mem_we == e_we) && (busy == e_busy) && (done == e_done);
        if (kind == 1 || kind == 2) ok = ok && (int'(mem_addr) == addr);
        if (kind == 2) ok = ok && (int'(mem_wdata) == data);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual re=%b we=%b busy=%b done=%b addr=%0d wdata=%h expected kind=%0d addr=%0d wdata=%h",
                     tag, mem_re, mem_we, busy, done, mem_addr, mem_wdata, kind, addr, data[15:0]);
        end
    endtask

    // Reference model built from the requirements
    task automatic build(logic [31:0] w0, logic [31:0] w1, logic [31:0] w2, logic msk);
        int sx, sy, dx, dy, wv, hv, n, a;
        int tmp[$];
        sx = int'(w0[9:0]);
        sy = int'(w0[24:16]);
        dx = int'(w1[9:0]);
        dy = int'(w1[24:16]);
        wv = (w2[9:0] == 0) ? 1024 : int'(w2[9:0]);       // R1
        hv = (w2[24:16] == 0) ? 512 : int'(w2[24:16]);    // R1
        if (sx == dx && sy == dy && !msk) begin           // R6
            q_kind.push_back(3); q_addr.push_back(0); q_data.push_back(0);
            return;
        end
        for (int r = 0; r < hv; r++) begin                // R7
            for (int c0 = 0; c0 < wv; c0 += 128) begin    // R3
                n = (wv - c0 > 128) ? 128 : wv - c0;
                tmp.delete();
                for (int k = 0; k < n; k++) begin
                    a = ((sy + r) % 512) * 1024 + ((sx + c0 + k) % 1024); // R2
                    tmp.push_back(int'(rget(a)));         // R4
                    q_kind.push_back(1); q_addr.push_back(a); q_data.push_back(0);
                end
                q_kind.push_back(0); q_addr.push_back(0); q_data.push_back(0);
                for (int k = 0; k < n; k++) begin
                    a = ((dy + r) % 512) * 1024 + ((dx + c0 + k) % 1024);
                    rmem[a] = 16'(tmp[k]) | (msk ? 16'h8000 : 16'h0000); // R5
                    q_kind.push_back(2); q_addr.push_back(a); q_data.push_back(int'(rmem[a]));
                end
            end
        end
        q_kind.push_back(3); q_addr.push_back(0); q_data.push_back(0);
    endtask

    task automatic run(string tag, logic [31:0] w0, logic [31:0] w1, logic [31:0] w2,
                       logic msk, logic inject);
        int step;
        build(w0, w1, w2, msk);
        @(negedge clk);
        pos_src = w0; pos_dst = w1; ext_size = w2; set_mask = msk; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        step = 0;
        while (q_kind.size() > 0) begin
            cmp(tag, q_kind.pop_front(), q_addr.pop_front(), q_data.pop_front());
            if (start) begin
                start = 1'b0;
            end else if (inject && step == 3) begin
                // R11: second request while busy, different words
                pos_src = 32'h0000_0000; pos_dst = 32'h0000_0000;
                ext_size = 32'h0001_0001; set_mask = 1'b0; start = 1'b1;
            end
            step++;
            @(negedge clk);
        end
        start = 1'b0;
        cmp({tag, " R8 idle after done"}, 4, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        cmp("R10 reset", 4, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp("R10 after release", 4, 0, 0);

        // R1 R2 R9: plain copy, junk in unused bits
        run("R1 R9 basic", 32'hFE05_FC0A, 32'h8028_412C, 32'hF003_0405, 1'b0, 1'b0);
        // R4 R3: overlapping rows, two pieces per row
        run("R4 R3 overlap", 32'h0014_0064, 32'h0014_0096, 32'h0002_00C8, 1'b0, 1'b0);
        // R2: source wraps on both axes
        run("R2 source wrap", 32'h01FE_03FC, 32'h003C_0028, 32'h0003_0009, 1'b0, 1'b0);
        // R2: destination wraps on both axes
        run("R2 dest wrap", 32'h0064_0005, 32'h01FF_03FE, 32'h0003_0006, 1'b0, 1'b0);
        // R5: mask forcing
        run("R5 mask", 32'h0000_0000, 32'h00C8_01F4, 32'h0002_0004, 1'b1, 1'b0);
        // R6: copy onto itself without mask is skipped
        run("R6 skip", 32'h0007_0007, 32'h0007_0007, 32'h0010_0010, 1'b0, 1'b0);
        // R5: copy onto itself with mask is performed
        run("R5 self mask", 32'h0007_0007, 32'h0007_0007, 32'h0001_0003, 1'b1, 1'b0);
        // R3: piece boundary exactly at 128, then 129
        run("R3 width 128", 32'h0050_0000, 32'h0051_0000, 32'h0001_0080, 1'b0, 1'b0);
        run("R3 width 129", 32'h0060_0010, 32'h0062_0020, 32'h0001_0081, 1'b0, 1'b0);
        // R1: width field 0 means 1024
        run("R1 full width", 32'h012C_0000, 32'h012D_0000, 32'h0001_0000, 1'b0, 1'b0);
        // R1 R7: height field 0 means 512, rows wrap
        run("R1 R7 full height", 32'h000A_0384, 32'h0000_0385, 32'h0000_0001, 1'b0, 1'b0);
        // R11: start during transfer is ignored
        run("R11 restart ignored", 32'h0030_0030, 32'h0040_0100, 32'h0002_0003, 1'b0, 1'b1);

        summary();
        $finish;
    end
endmodule